// File: doc/BRIEF.md
# Interrupt Presenter Register Front-End

This block sits between a simple request/acknowledge register bus and one per-thread interrupt presenter core. It decodes a 4 KiB window by word offset (address bits [11:2]) and by access width. Depending on the decoded operation, it does one of four things. It returns a value that the core exposes. It raises a single-cycle command strobe toward the core. It runs an accept handshake with the core and returns the pending word. Or it reads or writes one of three local 32-bit link registers.

The same offset can mean different operations at different widths. At the pending-word offset, a 4-byte read is destructive: it performs an accept. A 1-byte read at that offset only returns the current priority. Likewise, a 4-byte write there ends an interrupt, while a 1-byte write sets the current priority. Any offset and width combination that is not listed is rejected. A rejected read returns all ones, a rejected write changes nothing, and in both cases an error pulse reports the address and size.

Register data is big-endian. The current priority is therefore the most significant byte of the poll word. Byte reads return their byte right-justified in bits [7:0] of the read data, and byte writes take their byte from bits [7:0] of the write data.

Top module: `ipres_regfront`

## Requirements
- R1: After reset, bus_ack, acc_req and every command and error strobe are low, and all three link registers read as zero.
- R2: A 4-byte read at byte address 0x000 returns core_poll unchanged and raises no acc_req.
- R3: A 1-byte read at address 0x000 or 0x004 returns core_poll[31:24] in bus_rdata[7:0], with zeros above, and raises no acc_req.
- R4: A 4-byte read at 0x004 raises acc_req for exactly one cycle. bus_ack is raised one cycle after acc_ack, and bus_rdata carries the acc_word captured on that acc_ack.
- R5: A 4-byte write at 0x004 pulses eoi_stb, and eoi_val equals bus_wdata.
- R6: A 1-byte write at 0x004 pulses cppr_stb, and cppr_val equals bus_wdata[7:0].
- R7: At 0x00C, a 1-byte read returns core_ipi in bus_rdata[7:0], and a 1-byte write pulses ipi_stb with ipi_val equal to bus_wdata[7:0].
- R8: Link registers at 0x010, 0x014 and 0x018 are written and read only by 4-byte accesses, each independently. Their writes raise no core strobe.
- R9: An access is legal only when bus_addr[1:0] is 00. On top of that, bus_size must be 1 for a byte register or 4 for a word register. Sizes 2 and 3, sizes outside 1..4, and non-zero lanes are always illegal.
- R10: An illegal read returns 0xFFFFFFFF. An illegal write leaves every link register unchanged and raises no command strobe.
- R11: Every illegal access raises err_stb for one cycle, together with bus_ack, with err_off equal to bus_addr and err_size equal to bus_size. Legal accesses never raise err_stb.
- R12: bus_ack and each strobe last one cycle, at most one of eoi_stb/cppr_stb/ipi_stb/err_stb is high at a time, and each is high only together with bus_ack. Writes return zero on bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data (byte writes in [7:0]) |
| bus_ack | output | 1 | One-cycle completion |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| err_stb | output | 1 | Illegal access pulse |
| err_off | output | 12 | Address of the illegal access |
| err_size | output | 3 | Size of the illegal access |
| core_poll | input | 32 | Non-destructive pending word from the core |
| core_ipi | input | 8 | Current IPI priority from the core |
| acc_req | output | 1 | Accept request pulse to the core |
| acc_ack | input | 1 | Core reply to acc_req |
| acc_word | input | 32 | Pending word returned with acc_ack |
| eoi_stb | output | 1 | End-of-interrupt pulse |
| eoi_val | output | 32 | End-of-interrupt value |
| cppr_stb | output | 1 | Set-current-priority pulse |
| cppr_val | output | 8 | New current priority |
| ipi_stb | output | 1 | Set-IPI-priority pulse |
| ipi_val | output | 8 | New IPI priority |

## Verification
A decode fault shows up in the acknowledge cycle of the very access that triggers it, because response data, strobes and the error pulse are all registered in that cycle. The fault appears as a wrong read word, a missing or extra strobe, or an error pulse where none belongs. A fault in the accept path shows as a missing or doubled acc_req pulse, or as a response word that does not match the core's reply. A corrupted link register stays hidden until its next 4-byte read, so the random mix reads links often to keep that delay short.

// File: rtl/ipres_pkg.sv
// Shared types for the interrupt presenter register front-end.
// Assumes a 32-bit data path and word offsets taken from address bits [11:2].
package ipres_pkg;

    // Operation selected by offset, width and direction
    typedef enum logic [3:0] {
        OP_BAD,
        OP_RD_POLL,
        OP_RD_POLL_HI,
        OP_RD_ACCEPT,
        OP_RD_IPI,
        OP_RD_LINK,
        OP_WR_EOI,
        OP_WR_CPPR,
        OP_WR_IPI,
        OP_WR_LINK
    } op_e;

    // Access sequencer states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RESP
    } state_e;

    localparam int unsigned DATA_W = 32;

endpackage

// File: rtl/ipres_decode.sv
// Combinational access decoder.
// Maps address, size and direction to one operation and a link index.
// Assumes legal accesses start on lane 0; word accesses need size 4, byte accesses size 1.
module ipres_decode
    import ipres_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SIZE_W    = 3,
    parameter int unsigned LINK_N    = 3,
    parameter int unsigned LINK_BASE = 4,
    localparam int unsigned IDX_W    = ADDR_W - 2,
    localparam int unsigned LIDX_W   = (LINK_N > 1) ? $clog2(LINK_N) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              we,
    output op_e               op,
    output logic [LIDX_W-1:0] link_idx
);

    localparam logic [IDX_W-1:0] IDX_POLL  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_PEND  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_IPI   = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_LBASE = IDX_W'(LINK_BASE);
    localparam logic [IDX_W-1:0] IDX_LEND  = IDX_W'(LINK_BASE + LINK_N);

    logic [IDX_W-1:0] widx;
    logic [IDX_W-1:0] rel;
    logic             lane0;
    logic             is_byte;
    logic             is_word;

    // Classify width and lane, then pick the operation
    always_comb begin
        widx     = addr[ADDR_W-1:2];
        rel      = widx - IDX_LBASE;
        lane0    = (addr[1:0] == 2'b00);
        is_byte  = lane0 && (size == SIZE_W'(1));
        is_word  = lane0 && (size == SIZE_W'(4));
        op       = OP_BAD;
        link_idx = rel[LIDX_W-1:0];
        if (widx == IDX_POLL) begin
            if (!we && is_word)      op = OP_RD_POLL;
            else if (!we && is_byte) op = OP_RD_POLL_HI;
        end else if (widx == IDX_PEND) begin
            if (is_word)      op = we ? OP_WR_EOI  : OP_RD_ACCEPT;
            else if (is_byte) op = we ? OP_WR_CPPR : OP_RD_POLL_HI;
        end else if (widx == IDX_IPI) begin
            if (is_byte)      op = we ? OP_WR_IPI : OP_RD_IPI;
        end else if (widx >= IDX_LBASE && widx < IDX_LEND) begin
            if (is_word)      op = we ? OP_WR_LINK : OP_RD_LINK;
        end
    end

endmodule

// File: rtl/ipres_links.sv
// Bank of plain 32-bit link registers.
// Written one at a time, read through a mux, and cleared by reset.
// Assumes the caller qualifies we with a legal decoded access.
module ipres_links
    import ipres_pkg::*;
#(
    parameter int unsigned LINK_N  = 3,
    localparam int unsigned LIDX_W = (LINK_N > 1) ? $clog2(LINK_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LIDX_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LIDX_W-1:0] ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] q [LINK_N];

    for (genvar i = 0; i < LINK_N; i++) begin : g_reg
        // Hold one link value
        always_ff @(posedge clk) begin
            if (!rst_n)                               q[i] <= '0;
            else if (we && widx == LIDX_W'(i))        q[i] <= wdata;
        end

        AST_LINK_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (we && widx == LIDX_W'(i)) |=> (q[i] == $past(wdata))); // R8
        AST_LINK_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            !we |=> $stable(q[i])); // R10
    end

    // Select the addressed link for reading
    always_comb begin
        rdata = '0;
        for (int i = 0; i < LINK_N; i++)
            if (ridx == LIDX_W'(i)) rdata = q[i];
    end

endmodule

// File: rtl/ipres_regfront.sv
// Register front-end for one interrupt presenter thread.
// Decodes each bus access, answers it with a registered one-cycle bus_ack, and drives the
// matching core command strobe or error pulse in that same cycle.
// Assumes bus_req is held until bus_ack and dropped before the following cycle ends, and
// that the core answers each acc_req with one acc_ack.
module ipres_regfront
    import ipres_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SIZE_W    = 3,
    parameter int unsigned LINK_N    = 3,
    parameter int unsigned LINK_BASE = 4,
    parameter int unsigned PRIO_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic [31:0]       bus_rdata,
    output logic              err_stb,
    output logic [ADDR_W-1:0] err_off,
    output logic [SIZE_W-1:0] err_size,
    input  logic [31:0]       core_poll,
    input  logic [PRIO_W-1:0] core_ipi,
    output logic              acc_req,
    input  logic              acc_ack,
    input  logic [31:0]       acc_word,
    output logic              eoi_stb,
    output logic [31:0]       eoi_val,
    output logic              cppr_stb,
    output logic [PRIO_W-1:0] cppr_val,
    output logic              ipi_stb,
    output logic [PRIO_W-1:0] ipi_val
);

    localparam int unsigned LIDX_W = (LINK_N > 1) ? $clog2(LINK_N) : 1;

    op_e               op;
    logic [LIDX_W-1:0] link_idx;
    logic [31:0]       link_rdata;
    logic              start;
    logic              link_we;
    state_e            state;
    logic              we_q;

    ipres_decode #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINK_N(LINK_N), .LINK_BASE(LINK_BASE)
    ) u_decode (
        .addr(bus_addr), .size(bus_size), .we(bus_we), .op(op), .link_idx(link_idx)
    );

    ipres_links #(.LINK_N(LINK_N)) u_links (
        .clk(clk), .rst_n(rst_n), .we(link_we), .widx(link_idx),
        .wdata(bus_wdata), .ridx(link_idx), .rdata(link_rdata)
    );

    // A new access is taken only while idle
    always_comb begin
        start   = bus_req && (state == ST_IDLE);
        link_we = start && (op == OP_WR_LINK);
    end

    // Sequence each access and register its response and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            acc_req   <= 1'b0;
            eoi_stb   <= 1'b0;
            cppr_stb  <= 1'b0;
            ipi_stb   <= 1'b0;
            err_stb   <= 1'b0;
            eoi_val   <= '0;
            cppr_val  <= '0;
            ipi_val   <= '0;
            err_off   <= '0;
            err_size  <= '0;
            we_q      <= 1'b0;
        end else begin
            bus_ack  <= 1'b0;
            acc_req  <= 1'b0;
            eoi_stb  <= 1'b0;
            cppr_stb <= 1'b0;
            ipi_stb  <= 1'b0;
            err_stb  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        we_q      <= bus_we;
                        bus_rdata <= '0;
                        if (op == OP_RD_ACCEPT) begin
                            acc_req <= 1'b1;
                            state   <= ST_WAIT;
                        end else begin
                            bus_ack <= 1'b1;
                            state   <= ST_RESP;
                            case (op)
                                OP_RD_POLL:    bus_rdata <= core_poll;
                                OP_RD_POLL_HI: bus_rdata <= {24'h0, core_poll[31:24]};
                                OP_RD_IPI:     bus_rdata <= 32'(core_ipi);
                                OP_RD_LINK:    bus_rdata <= link_rdata;
                                OP_WR_EOI: begin
                                    eoi_stb <= 1'b1;
                                    eoi_val <= bus_wdata;
                                end
                                OP_WR_CPPR: begin
                                    cppr_stb <= 1'b1;
                                    cppr_val <= bus_wdata[PRIO_W-1:0];
                                end
                                OP_WR_IPI: begin
                                    ipi_stb <= 1'b1;
                                    ipi_val <= bus_wdata[PRIO_W-1:0];
                                end
                                OP_BAD: begin
                                    err_stb   <= 1'b1;
                                    err_off   <= bus_addr;
                                    err_size  <= bus_size;
                                    bus_rdata <= bus_we ? 32'h0 : 32'hFFFF_FFFF;
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                ST_WAIT: begin
                    if (acc_ack) begin
                        bus_rdata <= acc_word;
                        bus_ack   <= 1'b1;
                        state     <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R12
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eoi_stb, cppr_stb, ipi_stb, err_stb})); // R12
    AST_STB_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb || cppr_stb || ipi_stb || err_stb) |-> bus_ack); // R12
    AST_ACC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> (!acc_req && !bus_ack)); // R4
    AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stb && !we_q) |-> (bus_rdata == 32'hFFFF_FFFF)); // R10
    AST_ACK_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && acc_ack) |=> (bus_ack && bus_rdata == $past(acc_word))); // R4

endmodule

// File: tb/ipres_regfront_bench.sv
// Self-checking bench: directed corner cases plus seeded random accesses,
// with a behavioural presenter core stub.
module ipres_regfront_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        err_stb;
    logic [11:0] err_off;
    logic [2:0]  err_size;
    logic [31:0] core_poll = 32'h0;
    logic [7:0]  core_ipi = 8'h0;
    logic        acc_req, acc_ack;
    logic [31:0] acc_word;
    logic        eoi_stb, cppr_stb, ipi_stb;
    logic [31:0] eoi_val;
    logic [7:0]  cppr_val, ipi_val;

    int checks = 0;
    int errors = 0;
    logic [31:0] links_m [3];
    int unsigned acc_cnt = 0;

    always #10 clk = ~clk;

    ipres_regfront u_ipres_regfront (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .err_stb(err_stb),
        .err_off(err_off), .err_size(err_size), .core_poll(core_poll),
        .core_ipi(core_ipi), .acc_req(acc_req), .acc_ack(acc_ack),
        .acc_word(acc_word), .eoi_stb(eoi_stb), .eoi_val(eoi_val),
        .cppr_stb(cppr_stb), .cppr_val(cppr_val), .ipi_stb(ipi_stb), .ipi_val(ipi_val)
    );

    // Core stub: answer each accept one cycle later with a tagged word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_ack <= 1'b0;
            acc_cnt <= 0;
        end else begin
            acc_ack <= acc_req;
            if (acc_req) acc_cnt <= acc_cnt + 1;
        end
    end
    assign acc_word = {16'hA500, acc_cnt[15:0]};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Expected operation: 0 bad,1 poll,2 poll hi,3 accept,4 ipi rd,5 link rd,6 eoi,7 cppr,8 ipi wr,9 link wr
    function automatic int exp_op(input bit we, input logic [11:0] a, input logic [2:0] s);
        bit b = (a[1:0] == 0) && (s == 1);
        bit w = (a[1:0] == 0) && (s == 4);
        int idx = int'(a[11:2]);
        if (idx == 0 && !we) return w ? 1 : (b ? 2 : 0);
        if (idx == 1) begin
            if (w) return we ? 6 : 3;
            if (b) return we ? 7 : 2;
            return 0;
        end
        if (idx == 3 && b) return we ? 8 : 4;
        if (idx >= 4 && idx <= 6 && w) return we ? 9 : 5;
        return 0;
    endfunction

    // Run one access and check every port against the expected operation
    task automatic access(input bit we, input logic [11:0] a, input logic [2:0] s, input logic [31:0] wd);
        int op = exp_op(we, a, s);
        int unsigned cnt0 = acc_cnt;
        int acc_seen = 0;
        int wait_n = 0;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_size = s; bus_wdata = wd; bus_req = 1'b1;
        do begin
            @(negedge clk);
            if (acc_req) acc_seen++;
            wait_n++;
        end while (!bus_ack && wait_n < 20);
        chk(bus_ack, "R12 ack seen", {31'h0, bus_ack}, 32'h1);
        bus_req = 1'b0;
        case (op)
            1: chk(bus_rdata == core_poll, "R2 poll word", bus_rdata, core_poll);
            2: chk(bus_rdata == {24'h0, core_poll[31:24]}, "R3 poll byte", bus_rdata, {24'h0, core_poll[31:24]});
            3: begin
                chk(bus_rdata == {16'hA500, 16'(cnt0 + 1)}, "R4 accept word", bus_rdata, {16'hA500, 16'(cnt0 + 1)});
                chk(acc_seen == 1, "R4 one acc_req", acc_seen, 1);
            end
            4: chk(bus_rdata == {24'h0, core_ipi}, "R7 ipi read", bus_rdata, {24'h0, core_ipi});
            5: chk(bus_rdata == links_m[int'(a[11:2]) - 4], "R8 link read", bus_rdata, links_m[int'(a[11:2]) - 4]);
            6: chk(eoi_stb && eoi_val == wd, "R5 eoi", eoi_val, wd);
            7: chk(cppr_stb && cppr_val == wd[7:0], "R6 cppr", {24'h0, cppr_val}, {24'h0, wd[7:0]});
            8: chk(ipi_stb && ipi_val == wd[7:0], "R7 ipi write", {24'h0, ipi_val}, {24'h0, wd[7:0]});
            9: links_m[int'(a[11:2]) - 4] = wd;
            default: begin
                chk(err_stb && err_off == a && err_size == s, "R11 error report",
                    {16'h0, 1'b0, err_size, err_off}, {16'h0, 1'b0, s, a});
                if (!we) chk(bus_rdata == 32'hFFFF_FFFF, "R10 bad read ones", bus_rdata, 32'hFFFF_FFFF);
                chk(!eoi_stb && !cppr_stb && !ipi_stb, "R10 bad write no strobe",
                    {29'h0, eoi_stb, cppr_stb, ipi_stb}, 32'h0);
            end
        endcase
        if (op != 0) chk(!err_stb, "R11 no error on legal", {31'h0, err_stb}, 32'h0);
        if (op != 3) chk(acc_cnt == cnt0, "R3 no accept side effect", acc_cnt, cnt0);
        if (we) chk(bus_rdata == 32'h0, "R12 write rdata zero", bus_rdata, 32'h0);
        @(negedge clk);
        chk(!bus_ack && !err_stb && !eoi_stb && !cppr_stb && !ipi_stb, "R12 single cycle pulses",
            {27'h0, bus_ack, err_stb, eoi_stb, cppr_stb, ipi_stb}, 32'h0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) links_m[i] = '0;
        repeat (3) @(negedge clk);
        chk(!bus_ack && !acc_req && !err_stb && !eoi_stb && !cppr_stb && !ipi_stb, "R1 reset outputs",
            {26'h0, bus_ack, acc_req, err_stb, eoi_stb, cppr_stb, ipi_stb}, 32'h0);
        rst_n = 1'b1;
        core_poll = 32'hC3_12_34_56;
        core_ipi  = 8'h5A;
        // R1 links read zero after reset
        access(0, 12'h010, 3'd4, 0);
        access(0, 12'h014, 3'd4, 0);
        access(0, 12'h018, 3'd4, 0);
        // Directed cases
        access(0, 12'h000, 3'd4, 0);            // R2
        access(0, 12'h000, 3'd1, 0);            // R3
        access(0, 12'h004, 3'd1, 0);            // R3
        access(0, 12'h004, 3'd4, 0);            // R4
        access(0, 12'h004, 3'd4, 0);            // R4 second accept
        access(1, 12'h004, 3'd4, 32'hDEAD_BEEF);// R5
        access(1, 12'h004, 3'd1, 32'h0000_00F0);// R6
        access(0, 12'h00C, 3'd1, 0);            // R7
        access(1, 12'h00C, 3'd1, 32'h1234_5677);// R7
        access(1, 12'h010, 3'd4, 32'h1111_1111);// R8
        access(1, 12'h014, 3'd4, 32'h2222_2222);// R8
        access(1, 12'h018, 3'd4, 32'h3333_3333);// R8
        access(0, 12'h014, 3'd4, 0);            // R8
        access(1, 12'h010, 3'd2, 32'hFFFF_0000);// R9 size 2 illegal
        access(1, 12'h011, 3'd1, 32'h0000_00AA);// R9 lane 1 illegal
        access(1, 12'h014, 3'd1, 32'h0000_00AA);// R9 byte to link illegal
        access(0, 12'h010, 3'd4, 0);            // R10 link unchanged
        access(0, 12'h014, 3'd4, 0);            // R10 link unchanged
        access(1, 12'h000, 3'd4, 32'h5);        // R10 poll write illegal
        access(0, 12'h00C, 3'd4, 0);            // R9 word to ipi illegal
        access(0, 12'h004, 3'd3, 0);            // R9 size 3 illegal
        access(0, 12'h008, 3'd4, 0);            // R11 hole
        access(0, 12'hFFC, 3'd4, 0);            // R11 top of window
        access(0, 12'h004, 3'd0, 0);            // R9 size 0 illegal
        access(0, 12'h000, 3'd5, 0);            // R9 size 5 illegal
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            logic [2:0]  s;
            int pick = int'($urandom_range(0, 9));
            a = (pick < 8) ? 12'(pick * 4) : 12'($urandom_range(0, 4095));
            if ($urandom_range(0, 5) == 0) a[1:0] = 2'($urandom_range(1, 3));
            s = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : (($urandom_range(0, 1) == 1) ? 3'd4 : 3'd1);
            core_poll = $urandom();
            core_ipi  = 8'($urandom());
            access($urandom_range(0, 1) == 1, a, s, $urandom());
        end
        finish_run();
    end

endmodule